// File: doc/BRIEF.md
# Encoded I2C SCL Clock Divider

The block turns a packed 6-bit divider code into an integer ratio of system clocks per SCL period. It then runs a phase counter that marks each SCL half-period with a one-cycle tick. The code is not a plain count. Three scattered code bits index a small non-monotonic table of base values. Three further bits give a power-of-two exponent. A small correction term is added before the shift, and that term shrinks as the exponent field grows. A build-time variant picks between the base table and a doubled table, and the variant also sets its own exponent offset.

An I2C master uses `tick_o` as its half-period strobe and `scl_o` as the free-running SCL level. `ratio_o` shows the decoded ratio for the code on the input at that moment. A change of code takes effect only at the next half-period boundary, so no SCL phase is ever cut short.

Top module: `scl_clk_div`

## Requirements
- R1: The table index is {code[5], code[1], code[0]}, with code[5] as its MSB. The exponent field E is code[4:2].
- R2: In the base variant the ratio is (T + (6 >> E)) << (E + 1). T is the table value at the index, in index order 0..7: 9, 10, 12, 15, 5, 6, 7, 8.
- R3: In the doubled variant T is twice the table value. The correction term is (6 >> E) with bit 0 forced to 0. The shift is E + 4.
- R4: `ratio_o` is combinational in `code_i`. It holds steady while the code holds steady.
- R5: While `en_i` is low, `tick_o` stays 0, `scl_o` is 1 from the next clock edge on, and the phase counter is cleared.
- R6: After `en_i` rises, the first tick is sampled at the floor(ratio/2)-th rising edge at which `en_i` is high. That first half-period is the high phase (`scl_o` = 1).
- R7: Each tick toggles `scl_o` at the same edge. A high half-period lasts floor(ratio/2) clocks and a low half-period lasts ratio - floor(ratio/2) clocks. Two ticks never fall in consecutive cycles.
- R8: A code change in the middle of a half-period does not alter its length. The new ratio applies from the next half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the phase counter |
| code_i | input | 6 | Packed divider code |
| ratio_o | output | RATIO_W | Decoded system clocks per SCL period |
| tick_o | output | 1 | One-cycle strobe at the end of each half-period |
| scl_o | output | 1 | SCL level, high when idle |

## Verification
All 64 codes are swept through both variants. The sweep separates the scattered index bits from the exponent bits, the non-monotonic table order, and the two correction-term rules, including the exponent values at which the term drops to zero. Phase timing is measured on four codes whose ratios differ in table entry and exponent, which shows that the first tick, high and low lengths line up with the decode. A code swapped mid-phase shows that the running half-period keeps its length while the next one takes the new ratio. Idle stretches confirm that a disabled counter stays silent and holds SCL high.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int CODE_W = 6;
  localparam int IDX_W  = 3;
  localparam int EXP_W  = 3;

  typedef enum logic {VAR_BASE = 1'b0, VAR_DOUBLED = 1'b1} div_variant_e;

  // non-monotonic base table
  function automatic logic [4:0] base_entry(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0: base_entry = 5'd9;
      3'd1: base_entry = 5'd10;
      3'd2: base_entry = 5'd12;
      3'd3: base_entry = 5'd15;
      3'd4: base_entry = 5'd5;
      3'd5: base_entry = 5'd6;
      3'd6: base_entry = 5'd7;
      default: base_entry = 5'd8;
    endcase
  endfunction
endpackage

// File: rtl/scl_code_split.sv
module scl_code_split
  import scl_div_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [EXP_W-1:0]  exp_o
);
  assign idx_o = {code_i[5], code_i[1:0]};
  assign exp_o = code_i[4:2];
endmodule

// File: rtl/scl_ratio_calc.sv
module scl_ratio_calc
  import scl_div_pkg::*;
#(
  parameter div_variant_e VARIANT = VAR_BASE,
  parameter int           RATIO_W = 16
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [EXP_W-1:0]   exp_i,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam int TBL_SH  = (VARIANT == VAR_DOUBLED) ? 1 : 0;
  localparam int EXP_OFS = (VARIANT == VAR_DOUBLED) ? 4 : 1;

  logic [5:0]         tbl_val;
  logic [2:0]         corr_raw;
  logic [2:0]         corr_val;
  logic [6:0]         sum;
  logic [EXP_W:0]     shamt;

  assign tbl_val  = {1'b0, base_entry(idx_i)} << TBL_SH;
  assign corr_raw = 3'd6 >> exp_i;

  generate
    if (VARIANT == VAR_DOUBLED) begin : g_dbl
      assign corr_val = {corr_raw[2:1], 1'b0};
    end else begin : g_base
      assign corr_val = corr_raw;
    end
  endgenerate

  assign sum     = {1'b0, tbl_val} + {4'd0, corr_val};
  assign shamt   = {1'b0, exp_i} + (EXP_W+1)'(EXP_OFS);
  assign ratio_o = RATIO_W'(sum) << shamt;
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
  parameter int RATIO_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               tick_o,
  output logic               scl_o
);
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] hi_len;
  logic [RATIO_W-1:0] lo_len;
  logic [RATIO_W-1:0] cur_len;
  logic               scl_q;

  assign hi_len  = ratio_q >> 1;
  assign lo_len  = ratio_q - hi_len;   // odd ratio lengthens low phase
  assign cur_len = scl_q ? hi_len : lo_len;
  assign tick_o  = en_i && (cur_len != '0) && (cnt_q == cur_len - 1'b1);
  assign scl_o   = scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      scl_q   <= 1'b1;
    end else if (!en_i) begin
      cnt_q   <= '0;
      ratio_q <= ratio_i;
      scl_q   <= 1'b1;
    end else if (tick_o) begin
      cnt_q   <= '0;
      ratio_q <= ratio_i;   // reload only at a boundary
      scl_q   <= ~scl_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scl_clk_div.sv
module scl_clk_div
  import scl_div_pkg::*;
#(
  parameter div_variant_e VARIANT = VAR_BASE,
  parameter int           RATIO_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [5:0]         code_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               tick_o,
  output logic               scl_o
);
  logic [IDX_W-1:0] idx;
  logic [EXP_W-1:0] expo;

  scl_code_split u_split (
    .code_i (code_i),
    .idx_o  (idx),
    .exp_o  (expo)
  );

  scl_ratio_calc #(.VARIANT(VARIANT), .RATIO_W(RATIO_W)) u_calc (
    .idx_i   (idx),
    .exp_i   (expo),
    .ratio_o (ratio_o)
  );

  scl_phase_counter #(.RATIO_W(RATIO_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .ratio_i (ratio_o),
    .tick_o  (tick_o),
    .scl_o   (scl_o)
  );
endmodule

// File: rtl/scl_clk_div_chk.sv
module scl_clk_div_chk #(
  parameter int RATIO_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [5:0]         code_i,
  input logic [RATIO_W-1:0] ratio_o,
  input logic               tick_o,
  input logic               scl_o
);
  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);
  assert_idle_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> scl_o);
  assert_ratio_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(code_i) |-> $stable(ratio_o));
  assert_tick_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_o) |=> (scl_o != $past(scl_o)));
  assert_scl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_o) |=> $stable(scl_o));
  assert_tick_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

bind scl_clk_div scl_clk_div_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .code_i  (code_i),
  .ratio_o (ratio_o),
  .tick_o  (tick_o),
  .scl_o   (scl_o)
);

// File: tb/scl_clk_div_bench.sv
module scl_clk_div_bench;
  import scl_div_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int RATIO_W    = 16;
  localparam int TICK_LIMIT = 5000;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               en_b = 1'b0;
  logic               en_d = 1'b0;
  logic [5:0]         code = '0;
  logic [RATIO_W-1:0] ratio_b, ratio_d;
  logic               tick_b, tick_d, scl_b, scl_d;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_clk_div #(.VARIANT(VAR_BASE), .RATIO_W(RATIO_W)) u_scl_clk_div (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_b), .code_i(code),
    .ratio_o(ratio_b), .tick_o(tick_b), .scl_o(scl_b));

  scl_clk_div #(.VARIANT(VAR_DOUBLED), .RATIO_W(RATIO_W)) u_scl_clk_div_dbl (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_d), .code_i(code),
    .ratio_o(ratio_d), .tick_o(tick_d), .scl_o(scl_d));

  function automatic int exp_ratio(input int c, input bit dbl);
    int idx, e, t, corr;
    idx = ((c >> 3) & 4) | (c & 3);
    e   = (c >> 2) & 7;
    case (idx)
      0: t = 9;  1: t = 10; 2: t = 12; 3: t = 15;
      4: t = 5;  5: t = 6;  6: t = 7;  default: t = 8;
    endcase
    corr = 6 >> e;
    if (dbl) begin
      t    = t * 2;
      corr = corr & ~1;
      return (t + corr) << (e + 4);
    end
    return (t + corr) << (e + 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts negedge samples until tick seen
  task automatic wait_tick(input bit dbl, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!(dbl ? tick_d : tick_b) && k < TICK_LIMIT);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int k, r, kk;
    int codes[4] = '{6'h20, 6'h00, 6'h25, 6'h0B};
    #(CLK_PERIOD * 3);
    // reset state
    check("R5 reset scl", int'(scl_b), 1);
    check("R5 reset tick", int'(tick_b), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: full sweep, both variants
    for (int c = 0; c < 64; c++) begin
      code = 6'(c);
      #1;
      check("R1/R2 base ratio", int'(ratio_b), exp_ratio(c, 1'b0));
      check("R1/R3 doubled ratio", int'(ratio_d), exp_ratio(c, 1'b1));
      @(negedge clk);
      check("R4 ratio steady", int'(ratio_b), exp_ratio(c, 1'b0));
    end

    // R6 R7: phase timing, base variant
    foreach (codes[i]) begin
      code = 6'(codes[i]);
      r = exp_ratio(codes[i], 1'b0);
      @(negedge clk);
      en_b = 1'b1;
      wait_tick(1'b0, k);
      // sampled at the floor(r/2)-th enabled edge: r/2-1 negedges after raise
      check("R6 first tick", k, r/2 - 1);
      check("R6 high first", int'(scl_b), 1);
      wait_tick(1'b0, k);
      check("R7 low length", k, r - r/2);
      check("R7 scl low", int'(scl_b), 0);
      wait_tick(1'b0, k);
      check("R7 high length", k, r/2);
      check("R7 scl high", int'(scl_b), 1);
      en_b = 1'b0;
      // R5: idle stays quiet and high
      kk = 0;
      for (int j = 0; j < 40; j++) begin
        @(negedge clk);
        if (tick_b) kk++;
      end
      check("R5 idle ticks", kk, 0);
      check("R5 idle scl", int'(scl_b), 1);
    end

    // R8: code change mid-phase
    code = 6'h20;
    @(negedge clk);
    en_b = 1'b1;
    for (int j = 0; j < 3; j++) @(negedge clk);
    code = 6'h00;
    wait_tick(1'b0, k);
    check("R8 running phase kept", k + 3, exp_ratio(6'h20, 1'b0)/2 - 1);
    wait_tick(1'b0, k);
    check("R8 new low length", k, exp_ratio(6'h00, 1'b0) - exp_ratio(6'h00, 1'b0)/2);
    wait_tick(1'b0, k);
    check("R8 new high length", k, exp_ratio(6'h00, 1'b0)/2);
    en_b = 1'b0;

    // R3 R7: doubled variant timing
    code = 6'h20;
    r = exp_ratio(6'h20, 1'b1);
    @(negedge clk);
    en_d = 1'b1;
    wait_tick(1'b1, k);
    check("R6 doubled first tick", k, r/2 - 1);
    wait_tick(1'b1, k);
    check("R7 doubled low length", k, r - r/2);
    check("R7 doubled scl low", int'(scl_d), 0);
    en_d = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R5 doubled idle scl", int'(scl_d), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule